// File: doc/BRIEF.md
# Latched Fault Status Register

This block keeps an 8-bit record of fault and event conditions for a gate-driver controller. Each condition has a sticky latch. A momentary fault is therefore never lost between two host accesses. The serial command front end, which is outside this block, hands in decoded strobes:

- a strobe for each completed command;
- a strobe for a status read (opcode pattern 000x_xx00);
- a clear strobe that carries an 8-bit pattern.

The block returns the latched byte as the response word for every command.

A clear removes only the bits selected by a 1 in its pattern, using the same bit positions as the mask. A bit whose live condition is still high does not clear. The response word for a command is captured before that command's clear acts, so the host always sees the value that prompted it.

The over-temperature bit merges a sticky detector for each channel. The reset-event bit comes out of reset already set, which lets the host test the interrupt path at start-up. A registered interrupt line is the OR of every latched bit that is enabled by the host's mask.

Top module: `fault_stat_reg`

## Requirements
- R1: Status bit positions are fixed as follows:
  - bit 7 is the reset event;
  - bit 6 is write error;
  - bit 5 is framing error;
  - bit 4 is phase error;
  - bit 3 is overcurrent;
  - bit 2 is low supply;
  - bit 1 is desaturation;
  - bit 0 is over-temperature.
  Input `flt_live[k]` drives status bit k+1.
- R2: While `rst` is high at a clock edge, the status byte and the response byte become 8'h80 and the interrupt becomes 0.
- R3: A status bit that is 1 stays 1 on every cycle in which no clear strobe selects it, whether or not its condition is still present.
- R4: A clear strobe (`clr_valid`=1) drives to 0, at the next edge, every bit whose `clr_bits` position is 1 and whose set condition is low. Bits whose `clr_bits` position is 0 are unchanged.
- R5: A bit whose set condition is high at an edge is 1 after that edge, even if the same edge carries a clear for it.
- R6: Bit 0 is the OR of one sticky latch per temperature channel. A clear of bit 0 empties every channel latch whose input is low. Bit 0 therefore stays 1 while any channel input is high.
- R7: A pulse on `evt_rst_exit` sets bit 7, which then follows the same sticky and clear rules as the other bits.
- R8: On an edge where `cmd_done` or `rd_stat` is high, the response byte loads the status byte as it stood before that edge, so a clear in the same command is not yet visible. Without either strobe, the response byte holds its value.
- R9: The interrupt output, one edge later, is the OR over all bits of (status bit AND `mask_bits` bit). A bit whose mask is 0 never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_rst_exit | input | 1 | One-cycle pulse on leaving reset, sets bit 7 |
| flt_live | input | 6 | Live fault conditions for status bits 1 to 6 |
| flt_otemp | input | NUM_CH | Live temperature-limit condition for each channel |
| cmd_done | input | 1 | Any command completed; captures the response |
| rd_stat | input | 1 | Decoded status-read command; captures the response |
| clr_valid | input | 1 | Clear command strobe |
| clr_bits | input | 8 | Clear pattern, 1 selects a bit, in status layout |
| mask_bits | input | 8 | Interrupt enable for each status bit |
| stat_byte | output | 8 | Latched status byte |
| resp_byte | output | 8 | Response word returned for the last command |
| irq_o | output | 1 | Registered masked interrupt |

## Verification
A wrong latch value shows on `stat_byte` at the first sample after the edge that caused it. It also shows on `irq_o` one cycle later, for any enabled bit, and in `resp_byte` at the next command.

The bench sweeps every settable status pattern against sixteen clear patterns. It holds a pattern of conditions still active during each clear, and after each step it compares the status, the captured pre-clear response and the masked interrupt with values worked out arithmetically. A premature clear, a lost set or a clear that reaches unselected bits therefore appears within a single cycle of the stimulus.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int STAT_W   = 8;
  localparam int LIVE_W   = 6;
  localparam int B_OTEMP  = 0;
  localparam int B_RSTEVT = 7;
  localparam logic [STAT_W-1:0] STAT_RST_VAL = 8'h80;
  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/fsr_sticky_bit.sv
module fsr_sticky_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/fsr_otemp_merge.sv
module fsr_otemp_merge #(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ch_set_i,
  input  logic              clr_i,
  output logic              any_o
);
  logic [NUM_CH-1:0] ch_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    fsr_sticky_bit #(.RST_VAL(1'b0)) u_ch (
      .clk   (clk),
      .rst   (rst),
      .set_i (ch_set_i[c]),
      .clr_i (clr_i),
      .q_o   (ch_q[c])
    );
  end

  assign any_o = |ch_q;
endmodule

// File: rtl/fsr_capture.sv
module fsr_capture
  import fsr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  stat_t stat_i,
  input  logic  cap_i,
  input  stat_t mask_i,
  output stat_t resp_o,
  output logic  irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_o <= STAT_RST_VAL;
      irq_o  <= 1'b0;
    end else begin
      if (cap_i) resp_o <= stat_i;
      irq_o <= |(stat_i & mask_i);
    end
  end
endmodule

// File: rtl/fault_stat_reg.sv
module fault_stat_reg
  import fsr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_rst_exit,
  input  logic [LIVE_W-1:0] flt_live,
  input  logic [NUM_CH-1:0] flt_otemp,
  input  logic              cmd_done,
  input  logic              rd_stat,
  input  logic              clr_valid,
  input  logic [STAT_W-1:0] clr_bits,
  input  logic [STAT_W-1:0] mask_bits,
  output logic [STAT_W-1:0] stat_byte,
  output logic [STAT_W-1:0] resp_byte,
  output logic              irq_o
);
  stat_t clr_sel;
  stat_t stat_q;

  assign clr_sel = clr_valid ? clr_bits : '0;

  // Temperature bit: merged per-channel sticky detectors
  fsr_otemp_merge #(.NUM_CH(NUM_CH)) u_otemp (
    .clk      (clk),
    .rst      (rst),
    .ch_set_i (flt_otemp),
    .clr_i    (clr_sel[B_OTEMP]),
    .any_o    (stat_q[B_OTEMP])
  );

  // Single-source fault bits
  for (genvar b = 1; b <= LIVE_W; b++) begin : g_flt
    fsr_sticky_bit #(.RST_VAL(STAT_RST_VAL[b])) u_bit (
      .clk   (clk),
      .rst   (rst),
      .set_i (flt_live[b-1]),
      .clr_i (clr_sel[b]),
      .q_o   (stat_q[b])
    );
  end

  // Reset-event bit: comes out of reset set
  fsr_sticky_bit #(.RST_VAL(STAT_RST_VAL[B_RSTEVT])) u_rstevt (
    .clk   (clk),
    .rst   (rst),
    .set_i (evt_rst_exit),
    .clr_i (clr_sel[B_RSTEVT]),
    .q_o   (stat_q[B_RSTEVT])
  );

  fsr_capture u_cap (
    .clk    (clk),
    .rst    (rst),
    .stat_i (stat_q),
    .cap_i  (cmd_done | rd_stat),
    .mask_i (mask_bits),
    .resp_o (resp_byte),
    .irq_o  (irq_o)
  );

  assign stat_byte = stat_q;
endmodule

// File: rtl/fault_stat_reg_chk.sv
module fault_stat_reg_chk
  import fsr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              evt_rst_exit,
  input logic [LIVE_W-1:0] flt_live,
  input logic [NUM_CH-1:0] flt_otemp,
  input logic              cmd_done,
  input logic              rd_stat,
  input logic              clr_valid,
  input logic [STAT_W-1:0] clr_bits,
  input logic [STAT_W-1:0] mask_bits,
  input logic [STAT_W-1:0] stat_byte,
  input logic [STAT_W-1:0] resp_byte,
  input logic              irq_o
);
  stat_t set_v;
  assign set_v = {evt_rst_exit, flt_live, |flt_otemp};

  assert_reset_value_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stat_byte == STAT_RST_VAL && resp_byte == STAT_RST_VAL && !irq_o));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    !clr_valid |=> (($past(stat_byte) & ~stat_byte) == '0));

  assert_clear_selected_R4: assert property (@(posedge clk) disable iff (rst)
    clr_valid |=> ((stat_byte & $past(clr_bits & ~set_v)) == '0));

  assert_unselected_kept_R4: assert property (@(posedge clk) disable iff (rst)
    clr_valid |=> (($past(stat_byte & ~clr_bits) & ~stat_byte) == '0));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (set_v != '0) |=> ((stat_byte & $past(set_v)) == $past(set_v)));

  assert_otemp_live_R6: assert property (@(posedge clk) disable iff (rst)
    (|flt_otemp) |=> stat_byte[B_OTEMP]);

  assert_rst_exit_R7: assert property (@(posedge clk) disable iff (rst)
    evt_rst_exit |=> stat_byte[B_RSTEVT]);

  assert_resp_capture_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_done || rd_stat) |=> (resp_byte == $past(stat_byte)));

  assert_resp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(cmd_done || rd_stat) |=> $stable(resp_byte));

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past((stat_byte & mask_bits) != '0));
endmodule

bind fault_stat_reg fault_stat_reg_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/sim_fault_stat_reg.sv
`timescale 1ns/1ps
module sim_fault_stat_reg;
  localparam int NCH = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           evt_rst_exit = 1'b0;
  logic [5:0]     flt_live = '0;
  logic [NCH-1:0] flt_otemp = '0;
  logic           cmd_done = 1'b0;
  logic           rd_stat = 1'b0;
  logic           clr_valid = 1'b0;
  logic [7:0]     clr_bits = '0;
  logic [7:0]     mask_bits = '0;
  logic [7:0]     stat_byte;
  logic [7:0]     resp_byte;
  logic           irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fault_stat_reg #(.NUM_CH(NCH)) u0 (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive the inputs for one cycle: change them at the falling edge,
  // pass one rising edge, and return at the next falling edge.
  task automatic cyc(input logic [7:0] setv, input int och,
                     input logic cv, input logic [7:0] cb,
                     input logic cd, input logic rs, input logic [7:0] m);
    evt_rst_exit = setv[7];
    flt_live     = setv[6:1];
    flt_otemp    = '0;
    if (setv[0]) flt_otemp[och] = 1'b1;
    clr_valid = cv; clr_bits = cb;
    cmd_done  = cd; rd_stat  = rs;
    mask_bits = m;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input logic [7:0] m);
    cyc(8'h00, 0, 1'b0, 8'h00, 1'b0, 1'b0, m);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2: reset values
    chk("R2 stat", stat_byte, 8'h80);
    chk("R2 resp", resp_byte, 8'h80);
    chk("R2 irq", {7'd0, irq_o}, 8'h00);

    // R9: masked off reset-event gives no interrupt; enabled gives one
    idle(8'h7F);
    chk("R9 masked", {7'd0, irq_o}, 8'h00);
    idle(8'h80);
    chk("R9 enabled", {7'd0, irq_o}, 8'h01);
    chk("R3 rst-event sticky", stat_byte, 8'h80);

    // R4: a clear with all-zero pattern changes nothing
    cyc(8'h00, 0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00);
    chk("R4 zero pattern", stat_byte, 8'h80);

    // R8: status read captures; no strobe holds
    cyc(8'h00, 0, 1'b1, 8'h80, 1'b0, 1'b0, 8'h00);
    chk("R4 clear bit7", stat_byte, 8'h00);
    chk("R8 hold", resp_byte, 8'h80);
    cyc(8'h00, 0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00);
    chk("R8 rd_stat capture", resp_byte, 8'h00);

    // R7: reset-exit pulse sets bit 7
    cyc(8'h80, 0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
    chk("R7 set", stat_byte, 8'h80);

    // R6: channels 0 and 2 latched; clear bit 0 with channel 2 still live
    cyc(8'h00, 0, 1'b1, 8'hFF, 1'b0, 1'b0, 8'h00);
    flt_otemp = 3'b101;
    @(posedge clk); @(negedge clk);
    flt_otemp = '0;
    chk("R6 any channel", stat_byte, 8'h01);
    cyc(8'h01, 2, 1'b1, 8'h01, 1'b0, 1'b0, 8'h00);
    chk("R6 live channel keeps bit", stat_byte, 8'h01);
    idle(8'h00);
    chk("R6 sticky after live drops", stat_byte, 8'h01);
    cyc(8'h00, 0, 1'b1, 8'h01, 1'b0, 1'b0, 8'h00);
    chk("R6 cleared when none live", stat_byte, 8'h00);

    // R1: each live input lands on its own bit position
    for (int k = 0; k < 6; k++) begin
      cyc(8'h00, 0, 1'b1, 8'hFF, 1'b0, 1'b0, 8'h00);
      cyc(8'(1 << (k + 1)), 0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
      chk("R1 position", stat_byte, 8'(1 << (k + 1)));
    end

    // Sweep: every settable pattern against sixteen clear patterns
    for (int s = 0; s < 256; s++) begin
      for (int ci = 0; ci < 16; ci++) begin
        logic [7:0] sp, cp, lp, ev, mk;
        sp = 8'(s);
        cp = 8'(ci * 17 + s);
        lp = ((sp >> 1) ^ cp) & 8'h9B;
        mk = sp ^ 8'h3C;
        cyc(8'h00, 0, 1'b1, 8'hFF, 1'b0, 1'b0, 8'h00);
        chk("R4 clear all", stat_byte, 8'h00);
        cyc(sp, s % NCH, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
        chk("R1 set pattern", stat_byte, sp);
        cyc(lp, (s + 1) % NCH, 1'b1, cp, 1'b1, 1'b0, 8'h00);
        ev = (sp & ~cp) | lp;
        chk("R4 R5 clear result", stat_byte, ev);
        chk("R8 pre-clear response", resp_byte, sp);
        idle(mk);
        chk("R3 sticky", stat_byte, ev);
        chk("R9 masked irq", {7'd0, irq_o}, {7'd0, |(ev & mk)});
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule